// File: doc/BRIEF.md
# Core Countdown and Deadline Timer

This block is a per-core timer that raises an interrupt request carrying a programmable vector. It runs in one of three modes picked by a two-bit field in its control register: a one-shot countdown, a periodic countdown that reloads itself, or an absolute deadline that fires once a free-running 64-bit timestamp input reaches a programmed value. In the two countdown modes a prescaler divides the clock by a power of two between 1 and 128, and the current count falls by one per divided tick.

Software reaches the timer through one write port with a two-bit register select. The current count is always visible on an output. The interrupt leaves the block as a one-cycle pulse with its vector, and nothing is sent while the mask bit is set. The timer keeps running while masked. Writing zero disarms the timer. A mode change that crosses between deadline and countdown also disarms it.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, `cur_count` is 0, `irq_valid` is 0, the control register holds one-shot mode, unmasked, vector 0, and the divide code is 000. Writes take effect at the clock edge where `wr_en` is high. `wr_sel` selects the target: 0 control, 1 initial count, 2 divide code, 3 deadline.
- R2: In a countdown mode, writing initial count N≠0 loads N into the current count. With divide ratio D, the count drops by one every D cycles. After N·D edges it expires, and `irq_valid` is high for the one cycle that follows that edge.
- R3: In one-shot mode (mode 00, and the spare code 11), the count stays at 0 after expiry and no further interrupt follows until the initial count is written again.
- R4: In periodic mode (mode 01), expiry reloads the current count from the stored initial count. An interrupt follows every N·D cycles.
- R5: Writing 0 to the initial count in a countdown mode stops the timer. The count reads 0 and no interrupt follows.
- R6: A 3-bit divide code c selects ratio 2^(c+1) for c = 0..6, and ratio 1 for c = 7.
- R7: Every initial-count write in a countdown mode restarts the prescaler, so the first tick arrives D cycles after the write.
- R8: In deadline mode (mode 10), with a nonzero deadline value, the timer fires once the timestamp is equal to or greater than that value. The interrupt is seen one cycle later. The deadline then clears itself, so each write yields at most one interrupt.
- R9: Writing 0 to the deadline register disarms it.
- R10: A control write that moves between deadline mode and a countdown mode disarms both the countdown and the deadline. A switch between one-shot and periodic leaves a running countdown untouched.
- R11: Control bit 8 is the mask. While it is set, expiries still happen (reload or stop) but `irq_valid` stays low.
- R12: `irq_vector` carries control bits 7:0 as they were at expiry. In deadline mode `cur_count` reads 0, and an initial-count write there does not start a countdown. Control bits 10:9 hold the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 initial count, 2 divide, 3 deadline |
| wr_data | input | TS_W | Write data; low bits are used by the narrower registers |
| tsc | input | TS_W | Free-running timestamp compared in deadline mode |
| cur_count | output | CNT_W | Current countdown value (0 in deadline mode) |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
The countdown is exercised with random initial counts, every divide code, both countdown modes and random masking. Each cycle the bench compares the count and the interrupt against its own model, which separates a wrong divide ratio, an off-by-one expiry, and a missing or extra reload. Directed cases cover the rest. Two back-to-back initial writes show whether the prescaler restarts. Deadlines set above, equal to and below the timestamp exercise the greater-or-equal rule and the self-clear. Zero writes and mode swaps in both directions are each followed by a timestamp or a run time that would otherwise fire.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int VEC_W = 8;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_DEADLINE = 2'b10,
    MODE_SPARE    = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_INIT     = 2'd1,
    SEL_DIV      = 2'd2,
    SEL_DEADLINE = 2'd3
  } tsel_e;

  // packed layout: mode [10:9], mask [8], vector [7:0]
  typedef struct packed {
    tmode_e           mode;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } tctrl_t;

  function automatic logic is_deadline(input tmode_e m);
    return m == MODE_DEADLINE;
  endfunction

  // all-ones code selects 1, otherwise 2^(code+1)
  function automatic logic [31:0] div_ratio(input logic [31:0] code, input int unsigned dw);
    if (code == ((32'd1 << dw) - 32'd1)) return 32'd1;
    return 32'd1 << (code + 32'd1);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'(div_ratio(32'(div_code), DIV_W) - 32'd1);
    tick  = (pcnt_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             pcnt_q <= '0;
    else if (restart || tick) pcnt_q <= '0;
    else                    pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_countdown.sv
module tick_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur,
  output logic             armed,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = armed && tick && (cur == ONE) && !load && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cur   <= load_val;
      armed <= (load_val != '0);
    end else if (stop) begin
      cur   <= '0;
      armed <= 1'b0;
    end else if (expire) begin
      if (periodic) begin
        cur <= reload_val;
      end else begin
        cur   <= '0;
        armed <= 1'b0;
      end
    end else if (armed && tick) begin
      cur <= cur - ONE;
    end
  end
endmodule

// File: rtl/tick_deadline.sv
module tick_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [TS_W-1:0] wr_val,
  input  logic            clear,
  input  logic            enable,
  input  logic [TS_W-1:0] tsc,
  output logic            armed,
  output logic            expire
);
  logic [TS_W-1:0] target_q;

  assign armed  = (target_q != '0);
  assign expire = enable && armed && (tsc >= target_q) && !wr && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)                target_q <= '0;
    else if (wr)               target_q <= wr_val;
    else if (clear || expire)  target_q <= '0;
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [TS_W-1:0]  wr_data,
  input  logic [TS_W-1:0]  tsc,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int CTRL_W = $bits(tctrl_t);

  tctrl_t           ctrl_q;
  tctrl_t           ctrl_new;
  logic [CNT_W-1:0] init_q;
  logic [DIV_W-1:0] div_q;

  // named internal events
  logic wr_ctrl, wr_init, wr_div, wr_dl;
  logic mode_dl, periodic, mode_stop;
  logic init_load, init_zero;
  logic tick, expire_cd, expire_dl, cd_armed, dl_armed;
  logic [CNT_W-1:0] cur_q;

  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign wr_init  = wr_en && (wr_sel == SEL_INIT);
  assign wr_div   = wr_en && (wr_sel == SEL_DIV);
  assign wr_dl    = wr_en && (wr_sel == SEL_DEADLINE);
  assign ctrl_new = tctrl_t'(wr_data[CTRL_W-1:0]);

  assign mode_dl   = is_deadline(ctrl_q.mode);
  assign periodic  = (ctrl_q.mode == MODE_PERIODIC);
  assign mode_stop = wr_ctrl && (is_deadline(ctrl_new.mode) != mode_dl);
  assign init_load = wr_init && !mode_dl;
  assign init_zero = init_load && (wr_data[CNT_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      init_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_init) init_q <= wr_data[CNT_W-1:0];
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0];
    end
  end

  tick_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (init_load),
    .div_code (div_q),
    .tick     (tick)
  );

  tick_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (init_load),
    .load_val   (wr_data[CNT_W-1:0]),
    .stop       (mode_stop),
    .tick       (tick),
    .periodic   (periodic),
    .reload_val (init_q),
    .cur        (cur_q),
    .armed      (cd_armed),
    .expire     (expire_cd)
  );

  tick_deadline #(.TS_W(TS_W)) u_dl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_dl),
    .wr_val (wr_data),
    .clear  (mode_stop),
    .enable (mode_dl),
    .tsc    (tsc),
    .armed  (dl_armed),
    .expire (expire_dl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= (expire_cd || expire_dl) && !ctrl_q.mask;
      irq_vector <= ctrl_q.vec;
    end
  end

  assign cur_count = mode_dl ? '0 : cur_q;
endmodule

// File: rtl/tick_timer_checks.sv
module tick_timer_checks #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             mask_q,
  input logic             expire_cd,
  input logic             expire_dl,
  input logic             wr_dl,
  input logic             dl_armed,
  input logic             periodic,
  input logic             init_load,
  input logic             init_zero,
  input logic             mode_stop,
  input logic             cd_armed,
  input logic [CNT_W-1:0] cur_q,
  input logic [CNT_W-1:0] init_q
);
  assert_irq_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(expire_cd || expire_dl));

  assert_oneshot_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_cd && !periodic) |=> (!cd_armed && cur_q == '0));

  assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_cd && periodic) |=> (cur_q == $past(init_q) && cd_armed));

  assert_zero_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_zero |=> (!cd_armed && cur_q == '0));

  assert_dl_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_dl && !wr_dl) |=> !dl_armed);

  assert_mode_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stop |=> (!cd_armed && !dl_armed));

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q));

  assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_load && !init_zero) |=> cd_armed);
endmodule

bind core_tick_timer tick_timer_checks #(.CNT_W(CNT_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_valid (irq_valid),
  .mask_q    (ctrl_q.mask),
  .expire_cd (expire_cd),
  .expire_dl (expire_dl),
  .wr_dl     (wr_dl),
  .dl_armed  (dl_armed),
  .periodic  (periodic),
  .init_load (init_load),
  .init_zero (init_zero),
  .mode_stop (mode_stop),
  .cd_armed  (cd_armed),
  .cur_q     (cur_q),
  .init_q    (init_q)
);

// File: tb/test_core_tick_timer.sv
`timescale 1ns/1ps
module test_core_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] tsc = '0;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  core_tick_timer i_core_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tsc(tsc), .cur_count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always #2 clk = ~clk;

  function automatic int bench_ratio(int code);
    int r = 1;
    if (code == 7) return 1;
    for (int j = 0; j <= code; j++) r = r * 2;
    return r;
  endfunction

  function automatic logic [63:0] ctrl_word(int mode, bit msk, logic [7:0] vec);
    return 64'(mode) * 64'd512 + (msk ? 64'd256 : 64'd0) + 64'(vec);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after the write edge
  task automatic wr(logic [1:0] s, logic [63:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // countdown observation; t counts edges since the initial-count write
  task automatic obs_cd(int ncyc, int n, int r, bit per, int i0, bit msk,
                        logic [7:0] vec, string tag);
    for (int i = 1; i <= ncyc; i++) begin
      int t, k, ec;
      bit ef;
      @(negedge clk);
      t = i + i0;
      k = t / r;
      if (n == 0) begin ec = 0; ef = 0; end
      else if (per) begin ec = n - (k % n); ef = (t % (n * r)) == 0; end
      else begin ec = (k >= n) ? 0 : n - k; ef = (t == n * r); end
      if (msk) ef = 0;
      check(cur_count == 32'(ec), {tag, " count"}, cur_count, ec);
      check(irq_valid == ef, {tag, " irq"}, irq_valid, ef);
      if (ef) check(irq_vector == vec, {tag, " vector R12"}, irq_vector, vec);
    end
  endtask

  task automatic obs_dl(int ncyc, int fire_at, logic [7:0] vec, string tag);
    for (int i = 1; i <= ncyc; i++) begin
      bit ef;
      @(negedge clk);
      ef = (i == fire_at);
      check(cur_count == 0, {tag, " count R12"}, cur_count, 0);
      check(irq_valid == ef, {tag, " irq"}, irq_valid, ef);
      if (ef) check(irq_vector == vec, {tag, " vector R12"}, irq_vector, vec);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(cur_count == 0, "R1 count", cur_count, 0);
    check(irq_valid == 0, "R1 irq", irq_valid, 0);
    obs_cd(4, 0, 2, 0, 0, 0, 8'h00, "R1");

    // R2/R3 one-shot with divide 1
    wr(2'd0, ctrl_word(0, 0, 8'h31));
    wr(2'd2, 64'd7);
    wr(2'd1, 64'd5);
    obs_cd(14, 5, 1, 0, 0, 0, 8'h31, "R2/R3");

    // R3 spare mode code behaves as one-shot
    wr(2'd0, ctrl_word(3, 0, 8'h32));
    wr(2'd1, 64'd3);
    obs_cd(10, 3, 1, 0, 0, 0, 8'h32, "R3 spare");

    // R4 periodic, divide 4
    wr(2'd0, ctrl_word(1, 0, 8'h44));
    wr(2'd2, 64'd1);
    wr(2'd1, 64'd3);
    obs_cd(40, 3, 4, 1, 0, 0, 8'h44, "R4");

    // R7 prescaler restart: back-to-back initial writes at divide 4
    wr(2'd0, ctrl_word(0, 0, 8'h55));
    wr(2'd1, 64'd3);
    wr(2'd1, 64'd3);
    obs_cd(16, 3, 4, 0, 0, 0, 8'h55, "R7");

    // R5 zero write stops a periodic run
    wr(2'd0, ctrl_word(1, 0, 8'h66));
    wr(2'd2, 64'd7);
    wr(2'd1, 64'd5);
    obs_cd(2, 5, 1, 1, 0, 0, 8'h66, "R5 run");
    wr(2'd1, 64'd0);
    obs_cd(15, 0, 1, 1, 0, 0, 8'h66, "R5");

    // R10 one-shot to periodic switch keeps counting
    wr(2'd0, ctrl_word(0, 0, 8'h77));
    wr(2'd1, 64'd4);
    wr(2'd0, ctrl_word(1, 0, 8'h77));
    obs_cd(14, 4, 1, 1, 1, 0, 8'h77, "R10 keep");

    // R11 masked periodic still reloads
    wr(2'd0, ctrl_word(1, 1, 8'h88));
    wr(2'd1, 64'd3);
    obs_cd(12, 3, 1, 1, 0, 1, 8'h88, "R11");

    // R2/R4/R6/R11 random countdown runs
    for (int it = 0; it < 20; it++) begin
      int per, n, code, r;
      bit msk;
      logic [7:0] vec;
      per  = int'($urandom % 2);
      n    = 1 + int'($urandom % 6);
      code = int'($urandom % 8);
      msk  = ($urandom % 4) == 0;
      vec  = 8'($urandom);
      r    = bench_ratio(code);
      wr(2'd0, ctrl_word(per, msk, vec));
      wr(2'd2, 64'(code));
      wr(2'd1, 64'(n));
      obs_cd(2 * n * r + 3, n, r, per[0], 0, msk, vec, "R2/R4/R6");
    end

    // R8 deadline above, reached, then self-cleared
    wr(2'd0, ctrl_word(2, 0, 8'h41));
    tsc = 64'd100;
    wr(2'd3, 64'd105);
    obs_dl(4, 0, 8'h41, "R8 early");
    tsc = 64'd105;
    obs_dl(6, 1, 8'h41, "R8 equal");
    tsc = 64'd900;
    obs_dl(4, 0, 8'h41, "R8 once");
    wr(2'd3, 64'd50);
    obs_dl(4, 1, 8'h41, "R8 past");

    // R12 initial write in deadline mode does not count
    wr(2'd1, 64'd2);
    obs_dl(5, 0, 8'h41, "R12");

    // R9 zero write disarms
    tsc = 64'd100;
    wr(2'd3, 64'd200);
    wr(2'd3, 64'd0);
    tsc = 64'd300;
    obs_dl(5, 0, 8'h41, "R9");

    // R10 mode round trip disarms deadline
    tsc = 64'd100;
    wr(2'd3, 64'd400);
    wr(2'd0, ctrl_word(0, 0, 8'h42));
    wr(2'd0, ctrl_word(2, 0, 8'h42));
    tsc = 64'd500;
    obs_dl(5, 0, 8'h42, "R10 dl");
    wr(2'd3, 64'd400);
    obs_dl(3, 1, 8'h42, "R10 rearm");

    // R10 swap into deadline disarms a countdown
    wr(2'd0, ctrl_word(0, 0, 8'h43));
    wr(2'd2, 64'd7);
    wr(2'd1, 64'd20);
    obs_cd(3, 20, 1, 0, 0, 0, 8'h43, "R10 run");
    wr(2'd0, ctrl_word(2, 0, 8'h43));
    obs_dl(3, 0, 8'h43, "R10 swap");
    wr(2'd0, ctrl_word(0, 0, 8'h43));
    obs_cd(30, 0, 1, 0, 0, 0, 8'h43, "R10 cd");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule